// File: doc/BRIEF.md
# Phase-Accumulator Tone Generator

This block makes an audio tone on a single pulse-width output pin. A 16-bit phase word is advanced once per audio sample, and the sample taken from it becomes the duty level of a PWM carrier whose period is 250 clocks. The same phase word can give a square wave or a sawtooth. The level is scaled to the range 0 to 249 so that it never reaches the carrier period.

Control comes in as 32-bit command words. These are written into a small queue inside the block. At each sample tick the block takes at most one command, the oldest held. The command sets a new frequency and waveform, and the new phase step is used at once for that sample. The phase word itself is never cleared, so a change of note does not cause a step in the waveform. A frequency of zero silences the output.

Top module: `tone_gen`

## Requirements
- R1: After reset `level_o` is 0, `pwm_o` is low and `cmd_ready` is 1. The block is silent until a command with a non-zero frequency is applied.
- R2: The PWM carrier repeats every `PWM_WRAP` (250) clocks. In each period `pwm_o` is high for exactly the first `level_o` clocks.
- R3: A sample tick falls on the last clock of each carrier period. `level_o` changes only at that edge.
- R4: At a tick, if the queue holds a command, exactly one is removed, in arrival order, and it governs that same sample.
- R5: The phase step is round(f × 65536 / (CLK_HZ / PWM_WRAP)), which is round(f × 65536 / 500000) with the defaults. The phase is a 16-bit word that advances by the step at every tick and wraps modulo 65536.
- R6: In square mode the level is 249 while phase bit 15 is 0, and 0 while it is 1.
- R7: In sawtooth mode the level is floor(phase[15:8] × 249 / 255). It never exceeds 249.
- R8: Command layout: bits [15:0] hold the frequency in Hz. Bit 16 selects the waveform (0 square, 1 sawtooth). Bits [31:17] have no effect.
- R9: A command with frequency 0 holds the level at 0 from its tick until a non-zero frequency is applied.
- R10: Applying a command never resets the phase. The next phase is the old phase plus the new step.
- R11: The queue holds 4 commands. `cmd_ready` is low while it is full, and a word offered while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (125 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered this cycle |
| cmd_data | input | 32 | Command word: frequency [15:0], waveform [16] |
| cmd_ready | output | 1 | Queue can accept a word this cycle |
| pwm_o | output | 1 | PWM audio output pin |
| level_o | output | 8 | Duty level of the current carrier period |

## Verification
The assertions take some things for granted about the inputs. `rst_n` is held low long enough to clear every register. The frequency field stays small enough that its step fits in 16 bits; any 16-bit frequency meets this with the default clock. A word is counted as taken only when `cmd_valid` and `cmd_ready` are both high at a rising edge. The bench drives `cmd_valid` and `cmd_data` only on falling edges, and keeps every frequency within the 16-bit field. It offers words both while the queue is full and in the same cycle as a tick, so that drops and simultaneous write and removal are both exercised.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int PHASE_W = 16;
  localparam int CMD_W   = 32;

  typedef enum logic {
    WAVE_SQUARE = 1'b0,
    WAVE_SAW    = 1'b1
  } wave_t;

  typedef struct packed {
    logic [14:0]  spare;
    wave_t        wave;
    logic [15:0]  freq;
  } tone_cmd_t;

  // Rounded phase increment per sample; sample rate is clk_hz / wrap.
  function automatic logic [PHASE_W-1:0] step_for(input logic [15:0] freq,
                                                  input longint clk_hz,
                                                  input longint wrap);
    longint num;
    num = longint'(freq) * (longint'(1) <<< PHASE_W) * wrap;
    return PHASE_W'((num + clk_hz / 2) / clk_hz);
  endfunction

  // Duty level derived from the phase word; top is the largest legal level.
  function automatic logic [15:0] level_for(input wave_t wave,
                                            input logic [PHASE_W-1:0] ph,
                                            input logic mute,
                                            input int top);
    int scaled;
    if (mute) return 16'd0;
    if (wave == WAVE_SAW) begin
      scaled = int'(ph[PHASE_W-1 -: 8]) * top / 255;
      return 16'(scaled);
    end
    return ph[PHASE_W-1] ? 16'd0 : 16'(top);
  endfunction

endpackage

// File: rtl/cmd_queue.sv
module cmd_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = AW + 1;

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CNTW-1:0] count;
  logic            do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11: a full queue with no removal stays full (offered word dropped)
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  // R4: removal is only requested when a command is held
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int WRAP = 250,
  localparam int CW  = $clog2(WRAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          period_end
);
  assign period_end = (cnt == CW'(WRAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (period_end) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R2: counter stays in range and restarts after the last count
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(WRAP - 1)) |=> (cnt == '0));
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WRAP - 1));

endmodule

// File: rtl/tone_core.sv
module tone_core
  import tone_pkg::*;
#(
  parameter longint CLK_HZ = 125_000_000,
  parameter int     WRAP   = 250,
  localparam int    LVL_W  = $clog2(WRAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_avail,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             cmd_take,
  output logic [LVL_W-1:0] level_o
);
  tone_cmd_t          cmd;
  logic [PHASE_W-1:0] phase_q, step_q, phase_n, step_n;
  wave_t              wave_q, wave_n;
  logic               mute_q, mute_n;
  logic [LVL_W-1:0]   level_q, level_n;

  assign cmd      = tone_cmd_t'(cmd_word);
  assign cmd_take = tick && cmd_avail;

  always_comb begin
    step_n = step_q;
    wave_n = wave_q;
    mute_n = mute_q;
    if (cmd_take) begin
      step_n = step_for(cmd.freq, CLK_HZ, longint'(WRAP));
      wave_n = cmd.wave;
      mute_n = (cmd.freq == 16'd0);
    end
    phase_n = phase_q + step_n;
    level_n = LVL_W'(level_for(wave_n, phase_n, mute_n, WRAP - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      step_q  <= '0;
      wave_q  <= WAVE_SQUARE;
      mute_q  <= 1'b1;
      level_q <= '0;
    end else if (tick) begin
      phase_q <= phase_n;
      step_q  <= step_n;
      wave_q  <= wave_n;
      mute_q  <= mute_n;
      level_q <= level_n;
    end
  end

  assign level_o = level_q;

  // R3: level holds between ticks
  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level_q));
  // R7: level never reaches the carrier period
  a_r7_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(WRAP - 1));
  // R10: without a new command the phase advances by the held step
  a_r10_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cmd_take) |=> phase_q == PHASE_W'($past(phase_q) + $past(step_q)));
  // R9: a silenced tone produces level 0
  a_r9_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mute_n) |=> level_q == '0);

endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import tone_pkg::*;
#(
  parameter longint CLK_HZ   = 125_000_000,
  parameter int     PWM_WRAP = 250,
  parameter int     Q_DEPTH  = 4,
  localparam int    LVL_W    = $clog2(PWM_WRAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_data,
  output logic             cmd_ready,
  output logic             pwm_o,
  output logic [LVL_W-1:0] level_o
);
  logic             q_empty, q_full, q_pop, tick;
  logic [CMD_W-1:0] q_head;
  logic [LVL_W-1:0] pwm_cnt;

  assign cmd_ready = !q_full;

  cmd_queue #(.W(CMD_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_valid),
    .din   (cmd_data),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  pwm_timer #(.WRAP(PWM_WRAP)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (pwm_cnt),
    .period_end (tick)
  );

  tone_core #(.CLK_HZ(CLK_HZ), .WRAP(PWM_WRAP)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_avail (!q_empty),
    .cmd_word  (q_head),
    .cmd_take  (q_pop),
    .level_o   (level_o)
  );

  assign pwm_o = (pwm_cnt < level_o);

  // R2: a zero level keeps the pin low for the whole period
  a_r2_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0) |-> !pwm_o);
  // R4: a command is removed only on a sample tick
  a_r4_pop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> tick);

endmodule

// File: tb/tone_gen_tb.sv
`timescale 1ns/1ps
module tone_gen_tb;
  localparam int WRAP  = 250;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready, pwm_o;
  logic [7:0]  level_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tone_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .pwm_o(pwm_o), .level_o(level_o)
  );

  // Behavioural reference model
  int unsigned q[$];
  int m_cnt, m_phase, m_step, m_level;
  bit m_saw, m_mute;

  function automatic int exp_level(int ph, bit saw, bit mute);
    if (mute) return 0;
    if (saw) return (ph / 256) * 249 / 255;
    return (ph < 32768) ? 249 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_cnt = 0; m_phase = 0; m_step = 0; m_level = 0;
      m_saw = 0; m_mute = 1;
    end else begin
      bit tk, dp, dq;
      tk = (m_cnt == WRAP - 1);
      dp = tk && (q.size() > 0);
      dq = cmd_valid && (q.size() < DEPTH);
      if (dp) begin
        int unsigned c;
        longint f;
        c = q.pop_front();
        f = longint'(c & 32'hFFFF);
        m_saw  = c[16];
        m_mute = (f == 0);
        m_step = int'((f * 65536 + 250000) / 500000);
      end
      if (tk) begin
        m_phase = (m_phase + m_step) % 65536;
        m_level = exp_level(m_phase, m_saw, m_mute);
      end
      if (dq) q.push_back(cmd_data);
      m_cnt = tk ? 0 : m_cnt + 1;
    end
  end

  // Every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(level_o) != m_level) begin
        failures++;
        $display("FAIL R5/R6/R7 level mismatch t=%0t act=%0d exp=%0d saw=%0d",
                 $time, level_o, m_level, m_saw);
      end
      if (pwm_o != (m_cnt < m_level)) begin
        failures++;
        $display("FAIL R2 pwm mismatch t=%0t act=%0b exp=%0b", $time, pwm_o, (m_cnt < m_level));
      end
      if (cmd_ready != (q.size() < DEPTH)) begin
        failures++;
        $display("FAIL R11 ready mismatch t=%0t act=%0b exp=%0b", $time, cmd_ready, (q.size() < DEPTH));
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ticks(int n);
    repeat (n * WRAP) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 level after reset", int'(level_o), 0);
    check("R1 pwm after reset", int'(pwm_o), 0);
    check("R1 ready after reset", int'(cmd_ready), 1);
    wait_ticks(3);
    check("R9 silent before any command", int'(level_o), 0);

    // R8: junk in upper bits, 20000 Hz square
    send(32'hABCD_0000 & 32'hFFFE_0000 | 32'd20000);
    wait_ticks(2);
    check("R8 R6 square first half", int'(level_o), 249);
    wait_ticks(60);
    send(32'h0001_0000 | 32'd523);       // sawtooth C5
    wait_ticks(20);
    send(32'h0001_0000 | 32'd12000);     // R10 phase continues
    wait_ticks(60);
    check("R7 saw within range", int'(level_o <= 8'd249), 1);
    send(32'd0);                         // R9 mute
    wait_ticks(5);
    check("R9 mute level", int'(level_o), 0);
    check("R9 mute pin", int'(pwm_o), 0);

    // R11 / R4: fill the queue just after a tick
    while (m_cnt != 1) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (i == 4) check("R11 ready low when full", int'(cmd_ready), 0);
      cmd_valid = 1'b1;
      case (i)
        0: cmd_data = 32'h0001_0000 | 32'd30000;
        1: cmd_data = 32'd262;
        2: cmd_data = 32'd330;
        3: cmd_data = 32'h0001_0000 | 32'd392;
        default: cmd_data = 32'd9999;
      endcase
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check("R11 queue holds four", q.size(), 4);
    wait_ticks(1);
    check("R4 one removed per tick", q.size(), 3);
    wait_ticks(4);
    check("R4 queue drained, fifth dropped", q.size(), 0);
    check("R11 ready after drain", int'(cmd_ready), 1);

    // Mixed pattern with varied spacing, including offers on tick cycles
    for (int k = 0; k < 40; k++) begin
      int gap;
      gap = 60 + (k * 37) % 300;
      repeat (gap) @(negedge clk);
      send(((k % 2) ? 32'h0001_0000 : 32'h0) | 32'(1000 + k * 613));
    end
    wait_ticks(10);
    check("R5 final level model agreement", int'(level_o), m_level);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

endmodule